// File: doc/BRIEF.md
# External Bus Strobe Timing Generator

This block derives the two external-bus strobes of an 8-bit controller core from the oscillator clock. The core uses a 12-clock machine cycle. The block counts oscillator clocks into six states of two clocks each. From that state count it drives two strobes:

- An address-latch strobe that pulses twice per machine cycle.
- An active-low program-fetch read strobe that fires twice per machine cycle while code comes from external memory.

The sequencer reports three facts about each coming machine cycle:

- whether it is an external data transfer,
- whether it is a code-table read,
- whether code is being executed from external memory.

The block samples these reports, together with its own latch-strobe disable bit, on the last clock of every machine cycle. They then govern the whole of the following cycle. An external data transfer drops the first latch pulse and both fetch strobes of its cycle.

A one-byte control register sits behind a small address/data/write-enable port. Its bit 0 silences the latch strobe, which then rests high. While that bit is set, the latch strobe still runs in data-transfer and table-read cycles. The bit has no effect while executing from external memory.

Top module: `bus_strobe_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `ale` becomes 0, `psen_n` becomes 1, `mstate` becomes 0, and the control register and `cfg_rdata` become 0.
- R2: After reset is released, `mstate` counts 0,1,2,3,4,5 and repeats. Each value lasts two clocks, so one machine cycle is 12 clocks. State 0 is output on the first clock after reset release.
- R3: In a cycle that is neither an external data transfer nor silenced, `ale` is 1 during states 0 and 3 and 0 in the other states.
- R4: In an external data transfer cycle, the state-0 pulse of `ale` is omitted (0) and the state-3 pulse is kept.
- R5: In a cycle with external execution and no external data transfer, `psen_n` is 0 in states 1, 2, 4 and 5 and 1 in states 0 and 3.
- R6: In an external data transfer cycle, `psen_n` stays 1 for the whole cycle.
- R7: In a cycle with internal execution, `psen_n` stays 1 for the whole cycle.
- R8: If control bit 0 is 1, execution is internal, and the cycle has neither an external data transfer nor a table read, `ale` is 1 for all 12 clocks.
- R9: With control bit 0 set, a table-read or external data transfer cycle produces the same `ale` pattern as R3 and R4.
- R10: With control bit 0 set and external execution, `ale` follows R3 and R4 as if the bit were clear.
- R11: A write with `cfg_we`=1 and `cfg_addr`=0x8E stores `cfg_wdata` at the next edge. Writes to any other address change nothing. `cfg_rdata` returns the stored byte one clock after `cfg_addr` is 0x8E, and 0 for any other address.
- R12: `ext_exec`, `xdata_acc`, `movc_acc` and control bit 0 are sampled on the last clock of a machine cycle. They apply to all 12 clocks of the next cycle, and later changes have no effect until the next cycle boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_exec | input | 1 | Code executes from external program memory |
| xdata_acc | input | 1 | Coming machine cycle is an external data transfer |
| movc_acc | input | 1 | Coming machine cycle is a code-table read |
| cfg_addr | input | 8 | Control port address |
| cfg_wdata | input | 8 | Control port write data |
| cfg_we | input | 1 | Control port write enable |
| cfg_rdata | output | 8 | Control port read data, one clock after address |
| ale | output | 1 | Address-latch strobe, active high |
| psen_n | output | 1 | Program-fetch read strobe, active low |
| mstate | output | 3 | State index (0..5) that the strobes currently show |

## Verification
Every strobe and `mstate` value appears one clock after the counter position it decodes. The bench therefore reads its expected value for position j at the falling edge after the j-th rising edge of a cycle.

Cycle-type inputs and control writes are driven at the first falling edge of a cycle. The bench applies them to its model only from the first clock of the next machine cycle, matching the sampling on the last clock.

Read data lags its address by one clock. It is checked mid-cycle, several clocks after the last write and address change.

// File: rtl/bsg_pkg.sv
package bsg_pkg;
  // attributes that govern one whole machine cycle
  typedef struct packed {
    logic ext_exec;
    logic xdata;
    logic movc;
    logic ale_off;
  } cyc_attr_t;
endpackage

// File: rtl/bsg_phase_ctr.sv
module bsg_phase_ctr #(
  parameter int CPS = 2,
  parameter int NST = 6,
  localparam int SUB_W = (CPS > 1) ? $clog2(CPS) : 1,
  localparam int ST_W = (NST > 1) ? $clog2(NST) : 1
) (
  input  logic            clk,
  input  logic            rst,
  output logic [ST_W-1:0] st,
  output logic            cyc_last
);
  logic [SUB_W-1:0] sub;
  logic sub_end, st_end;

  assign sub_end  = (sub == SUB_W'(CPS - 1));
  assign st_end   = (st == ST_W'(NST - 1));
  assign cyc_last = sub_end && st_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      sub <= '0;
      st  <= '0;
    end else if (sub_end) begin
      sub <= '0;
      st  <= st_end ? '0 : st + ST_W'(1);
    end else begin
      sub <= sub + SUB_W'(1);
    end
  end

  // R2: machine cycle wraps to state 0 after the last clock
  p_cycle_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    cyc_last |=> (st == '0) && (sub == '0));
  // R2: each state advances by one after its clocks are used up
  p_state_step_r2: assert property (@(posedge clk) disable iff (rst)
    (sub_end && !st_end) |=> st == $past(st) + ST_W'(1));
  // R2: a state lasts its full clock count
  p_state_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !sub_end |=> $stable(st));
  p_state_range_r2: assert property (@(posedge clk) disable iff (rst)
    st < ST_W'(NST));
endmodule

// File: rtl/bsg_cfg_reg.sv
module bsg_cfg_reg #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [AW-1:0] ADDR = 8'h8E,
  parameter int OFF_BIT = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          we,
  output logic [DW-1:0] rdata,
  output logic          ale_off
);
  logic [DW-1:0] ctl;
  logic hit;

  assign hit     = (addr == ADDR);
  assign ale_off = ctl[OFF_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl   <= '0;
      rdata <= '0;
    end else begin
      if (we && hit) ctl <= wdata;
      rdata <= hit ? ctl : '0;
    end
  end

  // R11: a write to the register address lands at the next edge
  p_cfg_write_r11: assert property (@(posedge clk) disable iff (rst)
    (we && hit) |=> ctl == $past(wdata));
  // R11: writes elsewhere leave the register alone
  p_cfg_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !(we && hit) |=> $stable(ctl));
  p_cfg_miss_r11: assert property (@(posedge clk) disable iff (rst)
    !hit |=> rdata == '0);
endmodule

// File: rtl/bsg_cyc_latch.sv
module bsg_cyc_latch
  import bsg_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      cyc_last,
  input  cyc_attr_t nxt,
  output cyc_attr_t cur
);
  always_ff @(posedge clk) begin
    if (rst) cur <= '0;
    else if (cyc_last) cur <= nxt;
  end

  // R12: attributes only change at a machine cycle boundary
  p_attr_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !cyc_last |=> $stable(cur));
  p_attr_load_r12: assert property (@(posedge clk) disable iff (rst)
    cyc_last |=> cur == $past(nxt));
endmodule

// File: rtl/bsg_strobe_dec.sv
module bsg_strobe_dec
  import bsg_pkg::*;
#(
  parameter int NST = 6,
  localparam int ST_W = (NST > 1) ? $clog2(NST) : 1,
  localparam int HALF = NST / 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [ST_W-1:0] st,
  input  cyc_attr_t       cyc,
  output logic            ale,
  output logic            psen_n,
  output logic [ST_W-1:0] st_q
);
  logic first_slot, second_slot, ale_slot, silenced, fetch;

  // address phases sit at the start of each half cycle
  assign first_slot  = (st == '0);
  assign second_slot = (st == ST_W'(HALF));
  assign ale_slot    = (first_slot && !cyc.xdata) || second_slot;
  assign silenced    = cyc.ale_off && !cyc.ext_exec && !cyc.xdata && !cyc.movc;
  assign fetch       = cyc.ext_exec && !cyc.xdata && !first_slot && !second_slot;

  always_ff @(posedge clk) begin
    if (rst) begin
      ale    <= 1'b0;
      psen_n <= 1'b1;
      st_q   <= '0;
    end else begin
      ale    <= silenced ? 1'b1 : ale_slot;
      psen_n <= !fetch;
      st_q   <= st;
    end
  end

  // R7: no fetch strobe while executing internally
  p_psen_int_r7: assert property (@(posedge clk) disable iff (rst)
    !cyc.ext_exec |=> psen_n);
  // R6: no fetch strobe in a data transfer cycle
  p_psen_xdata_r6: assert property (@(posedge clk) disable iff (rst)
    cyc.xdata |=> psen_n);
  // R4: first latch pulse dropped in a data transfer cycle
  p_ale_skip_r4: assert property (@(posedge clk) disable iff (rst)
    (cyc.xdata && st == '0) |=> !ale);
  // R10: disable bit ignored under external execution
  p_ale_ext_r10: assert property (@(posedge clk) disable iff (rst)
    (cyc.ext_exec && st == ST_W'(1)) |=> !ale);
  // R8: silenced strobe rests high
  p_ale_rest_r8: assert property (@(posedge clk) disable iff (rst)
    (cyc.ale_off && !cyc.ext_exec && !cyc.xdata && !cyc.movc) |=> ale);
  // R3: strobes never overlap
  p_no_overlap_r3: assert property (@(posedge clk) disable iff (rst)
    !(ale && !psen_n));
endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
  import bsg_pkg::*;
#(
  parameter int CLKS_PER_STATE = 2,
  parameter int STATES = 6,
  parameter int CFG_AW = 8,
  parameter int CFG_DW = 8,
  parameter logic [CFG_AW-1:0] CFG_ADDR = 8'h8E,
  parameter int OFF_BIT = 0,
  localparam int ST_W = (STATES > 1) ? $clog2(STATES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_exec,
  input  logic              xdata_acc,
  input  logic              movc_acc,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  input  logic              cfg_we,
  output logic [CFG_DW-1:0] cfg_rdata,
  output logic              ale,
  output logic              psen_n,
  output logic [ST_W-1:0]   mstate
);
  logic [ST_W-1:0] st;
  logic cyc_last, ale_off;
  cyc_attr_t nxt_attr, cur_attr;

  bsg_phase_ctr #(.CPS(CLKS_PER_STATE), .NST(STATES)) u_phase (
    .clk(clk), .rst(rst), .st(st), .cyc_last(cyc_last)
  );

  bsg_cfg_reg #(.AW(CFG_AW), .DW(CFG_DW), .ADDR(CFG_ADDR), .OFF_BIT(OFF_BIT)) u_cfg (
    .clk(clk), .rst(rst), .addr(cfg_addr), .wdata(cfg_wdata), .we(cfg_we),
    .rdata(cfg_rdata), .ale_off(ale_off)
  );

  always_comb begin
    nxt_attr.ext_exec = ext_exec;
    nxt_attr.xdata    = xdata_acc;
    nxt_attr.movc     = movc_acc;
    nxt_attr.ale_off  = ale_off;
  end

  bsg_cyc_latch u_latch (
    .clk(clk), .rst(rst), .cyc_last(cyc_last), .nxt(nxt_attr), .cur(cur_attr)
  );

  bsg_strobe_dec #(.NST(STATES)) u_dec (
    .clk(clk), .rst(rst), .st(st), .cyc(cur_attr),
    .ale(ale), .psen_n(psen_n), .st_q(mstate)
  );
endmodule

// File: tb/bus_strobe_gen_tb.sv
module bus_strobe_gen_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_exec = 0, xdata_acc = 0, movc_acc = 0, cfg_we = 0;
  logic [7:0] cfg_addr = 8'h00, cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic ale, psen_n;
  logic [2:0] mstate;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  bus_strobe_gen u_dut (
    .clk(clk), .rst(rst), .ext_exec(ext_exec), .xdata_acc(xdata_acc),
    .movc_acc(movc_acc), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_we(cfg_we), .cfg_rdata(cfg_rdata), .ale(ale), .psen_n(psen_n),
    .mstate(mstate)
  );

  task automatic chk(string tag, int act, int exp, string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit exp_ale(int j, bit ex, bit xd, bit mc, bit off);
    int s = j / 2;
    if (off && !ex && !xd && !mc) return 1'b1;
    return ((s == 0) && !xd) || (s == 3);
  endfunction

  function automatic bit exp_psen(int j, bit ex, bit xd);
    int s = j / 2;
    return !(ex && !xd && (s % 3 != 0));
  endfunction

  function automatic string ale_tag(bit ex, bit xd, bit mc, bit off);
    if (off && !ex && !xd && !mc) return "R8";
    if (off && ex) return "R10";
    if (off) return "R9";
    if (xd) return "R4";
    return "R3";
  endfunction

  function automatic string psen_tag(bit ex, bit xd);
    if (!ex) return "R7";
    if (xd) return "R6";
    return "R5";
  endfunction

  initial begin
    #(20 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit c_ex, c_xd, c_mc, c_off;
    bit n_ex, n_xd, n_mc;
    logic [7:0] ctl;
    string ta;
    void'($urandom(32'h5eed_0042));
    c_ex = 0; c_xd = 0; c_mc = 0; c_off = 0;
    ctl = 8'h00;
    cfg_addr = 8'h8E;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", ale, 0, "ale in reset");
    chk("R1", psen_n, 1, "psen_n in reset");
    chk("R1", mstate, 0, "mstate in reset");
    chk("R1", cfg_rdata, 0, "cfg_rdata in reset");
    rst = 0;
    for (int c = 0; c < 400; c++) begin
      for (int j = 0; j < 12; j++) begin
        @(posedge clk);
        @(negedge clk);
        ta = (j == 0) ? "R12" : ale_tag(c_ex, c_xd, c_mc, c_off);
        chk("R2", mstate, j / 2, "mstate");
        chk(ta, ale, exp_ale(j, c_ex, c_xd, c_mc, c_off), "ale");
        chk((j == 0) ? "R12" : psen_tag(c_ex, c_xd), psen_n,
            exp_psen(j, c_ex, c_xd), "psen_n");
        if (j == 0) begin
          // choose attributes for the next machine cycle
          case (c)
            0: begin n_ex = 1; n_xd = 0; n_mc = 0; end
            1: begin n_ex = 1; n_xd = 1; n_mc = 0; end
            2: begin n_ex = 0; n_xd = 0; n_mc = 0; end
            3: begin n_ex = 0; n_xd = 0; n_mc = 0; end
            4: begin n_ex = 0; n_xd = 0; n_mc = 1; end
            5: begin n_ex = 0; n_xd = 1; n_mc = 0; end
            6: begin n_ex = 1; n_xd = 0; n_mc = 0; end
            7: begin n_ex = 1; n_xd = 1; n_mc = 0; end
            8: begin n_ex = 0; n_xd = 0; n_mc = 0; end
            9: begin n_ex = 1; n_xd = 0; n_mc = 1; end
            default: begin
              n_ex = 1'($urandom_range(0, 1));
              n_xd = ($urandom_range(0, 3) == 0);
              n_mc = ($urandom_range(0, 3) == 0);
            end
          endcase
          ext_exec = n_ex; xdata_acc = n_xd; movc_acc = n_mc;
          cfg_we = 0;
          if (c == 2) begin
            cfg_addr = 8'h8E; cfg_wdata = 8'hFF; cfg_we = 1;
          end else if (c == 6) begin
            cfg_addr = 8'h8F; cfg_wdata = 8'h00; cfg_we = 1;
          end else if (c == 8) begin
            cfg_addr = 8'h8E; cfg_wdata = 8'hFE; cfg_we = 1;
          end else if (c == 9) begin
            cfg_addr = 8'h8E; cfg_wdata = 8'h01; cfg_we = 1;
          end else if (c > 10 && $urandom_range(0, 3) == 0) begin
            cfg_addr = ($urandom_range(0, 1) == 1) ? 8'h8E : 8'($urandom_range(0, 255));
            cfg_wdata = 8'($urandom_range(0, 255));
            cfg_we = 1;
          end
          if (cfg_we && cfg_addr == 8'h8E) ctl = cfg_wdata;
        end else if (j == 1) begin
          cfg_we = 0;
          cfg_wdata = 8'($urandom_range(0, 255));
          cfg_addr = ($urandom_range(0, 2) != 0) ? 8'h8E : 8'($urandom_range(0, 255));
        end else if (j == 5) begin
          // R11: readback of stored byte, zero elsewhere
          chk("R11", cfg_rdata, (cfg_addr == 8'h8E) ? ctl : 0, "cfg_rdata");
        end else if (j == 7) begin
          // R12: late input changes inside a cycle must not matter
          ext_exec = ~ext_exec; xdata_acc = ~xdata_acc; movc_acc = ~movc_acc;
        end else if (j == 9) begin
          ext_exec = n_ex; xdata_acc = n_xd; movc_acc = n_mc;
        end
      end
      c_ex = n_ex; c_xd = n_xd; c_mc = n_mc; c_off = ctl[0];
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule